// File: doc/BRIEF.md
# Three-Wire Panel Configuration Serial Master

This block turns single register-access commands into frames on a slow three-wire configuration port. The three wires are an active-low select, a serial clock and one bidirectional data line. A command arrives on a valid/ready request port. It carries a direction flag, a 6-bit register address and, for writes, a data byte. The block shifts the frame out most-significant bit first. The clock idles low, data changes only while the clock is low, and the panel samples on the rising edge. For a read, the block releases the data line for a turnaround bit and then collects eight bits driven by the panel. When the frame ends, the block pulses `done`. For a read it also presents the received byte on `rdata`.

All serial timing comes from the system clock period and four nanosecond parameters: minimum pulse width, setup, hold and the idle gap between commands. Each value is rounded up to whole system cycles. One half-period count serves as both the clock high time and the clock low time. This gives an exact 50% duty cycle and still meets the pulse width, setup and hold minimums. The pad itself sits outside the block. The block only provides the data value, an output-enable, and an input sample of the pin.

Top module: `panel_cfg_master`

## Requirements
- R1: A write frame has exactly 16 rising clock edges. The data line sampled at those edges carries the address (bit 5 first), then two 0 bits, then the data byte (bit 7 first), and output-enable is high at every edge.
- R2: A read frame has exactly 16 rising edges. The first six edges carry the address (bit 5 first) and the seventh carries a 1, all with output-enable high. Output-enable is low at edges 8 to 16.
- R3: In a read, the panel bits sampled at edges 9 to 16 form `rdata`, first sample in bit 7. `done` is a one-cycle pulse after each frame, and `rdata` is valid in that cycle.
- R4: Inside a frame, every clock high time and every clock low time equals H system cycles. H = max(ceil(PULSE_NS/T), ceil(SETUP_NS/T), ceil(HOLD_NS/T), 1), where T is the clock period in ns.
- R5: `sda_out` and `sda_oe` never change while `sclk` stays high.
- R6: `cs_n` falls H cycles before the first rising edge and rises H cycles after the last falling edge. `sclk` is low whenever `cs_n` is high.
- R7: Between the rise of `cs_n` and its next fall, at least G = ceil(GAP_NS/T) cycles pass.
- R8: `req_ready` is low from the cycle after acceptance until the gap has elapsed. A request presented while `req_ready` is low is ignored and does not alter the frame in progress.
- R9: After reset, `cs_n`=1, `sclk`=0, `sda_oe`=0, `done`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Block can accept a command |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | 6 | Panel register address |
| req_wdata | input | 8 | Byte to write |
| done | output | 1 | One-cycle pulse at end of frame |
| rdata | output | 8 | Byte returned by a read |
| cs_n | output | 1 | Active-low select |
| sclk | output | 1 | Serial clock |
| sda_out | output | 1 | Data value to the pad |
| sda_oe | output | 1 | Pad output enable |
| sda_in | input | 1 | Pad input value |

## Verification
The hardest behaviour to reach from the ports is a stray request that arrives mid-frame. The bench keeps `req_valid` high with inverted direction, address and data for the whole frame. It drops the request only after `done`, so the block must ignore it for the entire busy window. The read path depends on a panel model that changes the line only on falling clock edges after the turnaround bit. The bench sweeps all 64 addresses for both writes and reads, with a distinct byte each time. Commands are issued back to back, so every gap measurement comes from the shortest wait the block allows.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_HIGH,
    PH_LOW,
    PH_TAIL,
    PH_GAP
  } phase_t;

  // nanoseconds to whole system cycles, rounded up, never zero
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ps);
    int unsigned c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pcfg_timer.sv
module pcfg_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

  // R4
  timer_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt == '0) |=> (cnt == '0));

endmodule

// File: rtl/pcfg_shift.sv
module pcfg_shift #(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_word,
  input  logic               tx_adv,
  input  logic               rx_cap,
  input  logic               rx_bit,
  output logic               tx_msb,
  output logic [DATA_W-1:0]  rx_byte
);

  logic [FRAME_W-1:0] tx_q;
  logic [DATA_W-1:0]  rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0;
    end else if (load) begin
      tx_q <= load_word;
    end else if (tx_adv) begin
      tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q <= '0;
    end else if (load) begin
      rx_q <= '0;
    end else if (rx_cap) begin
      rx_q <= {rx_q[DATA_W-2:0], rx_bit};
    end
  end

  assign tx_msb  = tx_q[FRAME_W-1];
  assign rx_byte = rx_q;

  // R3
  rx_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_cap && !load) |=> (rx_q[0] == $past(rx_bit)));

endmodule

// File: rtl/panel_cfg_master.sv
module panel_cfg_master #(
  parameter int unsigned CLK_PS   = 5000,
  parameter int unsigned PULSE_NS = 160,
  parameter int unsigned SETUP_NS = 150,
  parameter int unsigned HOLD_NS  = 150,
  parameter int unsigned GAP_NS   = 1000,
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_read,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              cs_n,
  output logic              sclk,
  output logic              sda_out,
  output logic              sda_oe,
  input  logic              sda_in
);
  import pcfg_pkg::*;

  localparam int unsigned FRAME_W = ADDR_W + 2 + DATA_W;
  localparam int unsigned HALF_C  = max2(ns_to_cyc(PULSE_NS, CLK_PS),
                                         max2(ns_to_cyc(SETUP_NS, CLK_PS),
                                              ns_to_cyc(HOLD_NS, CLK_PS)));
  localparam int unsigned GAP_C   = ns_to_cyc(GAP_NS, CLK_PS);
  localparam int unsigned CNT_W   = $clog2(max2(HALF_C, GAP_C) + 1);
  localparam int unsigned IDX_W   = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] TURN_IDX = IDX_W'(ADDR_W + 1);
  localparam logic [CNT_W-1:0] HALF_LD  = CNT_W'(HALF_C - 1);
  localparam logic [CNT_W-1:0] GAP_LD   = CNT_W'(GAP_C - 1);

  phase_t           phase;
  logic [IDX_W-1:0] bit_idx;
  logic             is_read_q;
  logic             cs_n_q, sclk_q, oe_q, ready_q, done_q;
  logic [DATA_W-1:0] rdata_q;

  logic             accept;
  logic             tmr_load, tmr_exp;
  logic [CNT_W-1:0] tmr_val;
  logic             tx_adv, rx_cap, tx_msb;
  logic [FRAME_W-1:0] frame_word;
  logic [DATA_W-1:0]  rx_byte;

  assign accept = (phase == PH_IDLE) && ready_q && req_valid;

  // frame image: address, then direction field, then payload or idle zeros
  always_comb begin
    if (req_read) begin
      frame_word = {req_addr, 1'b1, {(DATA_W + 1){1'b0}}};
    end else begin
      frame_word = {req_addr, 2'b00, req_wdata};
    end
  end

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = HALF_LD;
    tx_adv   = 1'b0;
    rx_cap   = 1'b0;
    unique case (phase)
      PH_IDLE: tmr_load = accept;
      PH_LEAD, PH_LOW: begin
        tmr_load = tmr_exp;
        rx_cap   = tmr_exp && is_read_q && (bit_idx > TURN_IDX);
      end
      PH_HIGH: begin
        tmr_load = tmr_exp;
        tx_adv   = tmr_exp && (bit_idx != LAST_IDX);
      end
      PH_TAIL: begin
        tmr_load = tmr_exp;
        tmr_val  = GAP_LD;
      end
      default: tmr_load = 1'b0;
    endcase
  end

  pcfg_timer #(.W(CNT_W)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  pcfg_shift #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) i_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_word (frame_word),
    .tx_adv    (tx_adv),
    .rx_cap    (rx_cap),
    .rx_bit    (sda_in),
    .tx_msb    (tx_msb),
    .rx_byte   (rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      bit_idx   <= '0;
      is_read_q <= 1'b0;
      cs_n_q    <= 1'b1;
      sclk_q    <= 1'b0;
      oe_q      <= 1'b0;
      ready_q   <= 1'b1;
      done_q    <= 1'b0;
      rdata_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase     <= PH_LEAD;
            bit_idx   <= '0;
            is_read_q <= req_read;
            cs_n_q    <= 1'b0;
            oe_q      <= 1'b1;
            ready_q   <= 1'b0;
          end
        end
        PH_LEAD, PH_LOW: begin
          if (tmr_exp) begin
            phase  <= PH_HIGH;
            sclk_q <= 1'b1;
          end
        end
        PH_HIGH: begin
          if (tmr_exp) begin
            sclk_q <= 1'b0;
            if (bit_idx == LAST_IDX) begin
              phase <= PH_TAIL;
            end else begin
              phase   <= PH_LOW;
              bit_idx <= bit_idx + 1'b1;
              if (is_read_q && (bit_idx + 1'b1 == TURN_IDX)) begin
                oe_q <= 1'b0;
              end
            end
          end
        end
        PH_TAIL: begin
          if (tmr_exp) begin
            phase   <= PH_GAP;
            cs_n_q  <= 1'b1;
            oe_q    <= 1'b0;
            done_q  <= 1'b1;
            rdata_q <= rx_byte;
          end
        end
        PH_GAP: begin
          if (tmr_exp) begin
            phase   <= PH_IDLE;
            ready_q <= 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign req_ready = ready_q;
  assign done      = done_q;
  assign rdata     = rdata_q;
  assign cs_n      = cs_n_q;
  assign sclk      = sclk_q;
  assign sda_out   = tx_msb;
  assign sda_oe    = oe_q;

  // R5
  sda_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk_q && $past(sclk_q)) |-> ($stable(sda_out) && $stable(oe_q)));

  // R6
  clk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n_q |-> !sclk_q);

  // R8
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |-> !ready_q);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R2
  turnaround_release_chk: assert property (@(posedge clk) disable iff (rst)
    (is_read_q && sclk_q && (bit_idx >= TURN_IDX)) |-> !oe_q);

  // R7
  gap_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_q) |-> !ready_q);

endmodule

// File: tb/test_panel_cfg_master.sv
module test_panel_cfg_master;

  localparam int CLK_PS = 5000;
  localparam int PULSE  = 20;
  localparam int SETUP  = 15;
  localparam int HOLD   = 15;
  localparam int GAPNS  = 50;
  localparam int CP     = (PULSE * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int CS     = (SETUP * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int CH     = (HOLD * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int H_E    = (CP > CS) ? ((CP > CH) ? CP : CH) : ((CS > CH) ? CS : CH);
  localparam int G_E    = (GAPNS * 1000 + CLK_PS - 1) / CLK_PS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_read = 1'b0, sda_in = 1'b0;
  logic [5:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, done, cs_n, sclk, sda_out, sda_oe;
  logic [7:0] rdata;

  always #2.5 clk = ~clk;

  panel_cfg_master #(
    .CLK_PS(CLK_PS), .PULSE_NS(PULSE), .SETUP_NS(SETUP), .HOLD_NS(HOLD), .GAP_NS(GAPNS)
  ) i_panel_cfg_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_read(req_read), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .cs_n(cs_n), .sclk(sclk),
    .sda_out(sda_out), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // panel model and line monitor, all at the falling system-clock edge
  logic        prev_sclk = 1'b0, prev_cs = 1'b1;
  int          rises = 0, run = 0, cyc = 0, cs_rise_at = -1, cs_falls = 0, dones = 0;
  logic [15:0] bits, oes;
  bit          clk_bad = 0, edge_bad = 0, gap_bad = 0, panel_read = 0;
  logic [7:0]  pbyte = '0, got_rdata = '0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (done) begin
        dones++;
        got_rdata = rdata;
      end
      if (prev_cs && !cs_n) begin
        cs_falls++;
        rises = 0;
        run = 1;
        bits = '0;
        oes = '0;
        if (cs_rise_at >= 0 && (cyc - cs_rise_at) < G_E) gap_bad = 1;
      end else if (!prev_cs && cs_n) begin
        cs_rise_at = cyc;
        if (run != H_E) edge_bad = 1;
      end else if (!cs_n) begin
        if (sclk == prev_sclk) begin
          run++;
        end else begin
          if (run != H_E) begin
            if (sclk && rises == 0) edge_bad = 1;
            else clk_bad = 1;
          end
          run = 1;
          if (sclk) begin
            if (rises < 16) begin
              bits[15-rises] = sda_out;
              oes[15-rises]  = sda_oe;
            end
            rises++;
          end else if (panel_read && rises >= 8 && rises <= 15) begin
            sda_in = pbyte[15-rises];
          end
        end
      end
      prev_sclk = sclk;
      prev_cs   = cs_n;
    end
  end

  task automatic xact(input bit rd, input logic [5:0] a, input logic [7:0] d);
    int d0, f0;
    logic [15:0] exp_bits, exp_oe;
    while (!req_ready) @(negedge clk);
    panel_read = rd;
    pbyte = d;
    d0 = dones;
    f0 = cs_falls;
    req_valid = 1'b1;
    req_read  = rd;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    // R8: stray request held during the whole frame
    req_read  = ~rd;
    req_addr  = ~a;
    req_wdata = ~d;
    #0;
    chk(req_ready == 1'b0, "R8 ready low after accept", req_ready, 0);
    while (dones == d0) @(negedge clk);
    req_valid = 1'b0;
    exp_bits = rd ? {a, 1'b1, 9'b0} : {a, 2'b00, d};
    exp_oe   = rd ? 16'hFE00 : 16'hFFFF;
    if (rd) begin
      chk(bits[15:9] == exp_bits[15:9], "R2 read header", bits[15:9], exp_bits[15:9]);
      chk(oes == exp_oe, "R2 oe pattern", oes, exp_oe);
      chk(got_rdata == d, "R3 read byte", got_rdata, d);
    end else begin
      chk(bits == exp_bits, "R1 write bits", bits, exp_bits);
      chk(oes == exp_oe, "R1 oe pattern", oes, exp_oe);
    end
    chk(rises == 16, rd ? "R2 edge count" : "R1 edge count", rises, 16);
    chk(cs_falls == f0 + 1, "R8 stray request ignored", cs_falls - f0, 1);
    chk(dones == d0 + 1, "R3 single done", dones - d0, 1);
    chk(!clk_bad, "R4 half-period", clk_bad, 0);
    chk(!edge_bad, "R6 select lead/tail", edge_bad, 0);
    chk(!gap_bad, "R7 command gap", gap_bad, 0);
    clk_bad = 0;
    edge_bad = 0;
    gap_bad = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9
    chk(cs_n == 1'b1 && sclk == 1'b0 && sda_oe == 1'b0 && done == 1'b0 && req_ready == 1'b1,
        "R9 reset state", {cs_n, sclk, sda_oe, done, req_ready}, 5'b10001);
    for (int i = 0; i < 64; i++) xact(1'b0, 6'(i), 8'((i * 37 + 5) & 8'hFF));
    for (int i = 0; i < 64; i++) xact(1'b1, 6'(i), 8'(i[5:0] ^ 8'hA5) ^ 8'(i << 2));
    xact(1'b0, 6'h3F, 8'hFF);
    xact(1'b0, 6'h00, 8'h00);
    xact(1'b1, 6'h3F, 8'h00);
    xact(1'b1, 6'h00, 8'hFF);
    xact(1'b1, 6'h2A, 8'h81);
    repeat (G_E + 5) @(negedge clk);
    // R5/R6: idle line after the last command
    chk(cs_n == 1'b1 && sclk == 1'b0 && sda_oe == 1'b0, "R6 idle after frames",
        {cs_n, sclk, sda_oe}, 3'b100);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule